// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of eight interrupt sources the core should service next. Hardware request lines and one-cycle software request pulses pass through a programmable enable mask. They are then recorded in sticky pending bits, so a short pulse is never lost while the core is busy with something else.

Sources are ranked by index, and index 0 ranks highest. A pending source is taken only when it outranks the level currently in service. When a source is taken, the controller presents that source's entry in a 16-byte vector table, raises a request strobe and stops arbitrating. It starts again after the core has accepted the request, through a fixed three-stage acknowledge delay. The core can step the vector address by one to reach the second byte of a two-byte vector. A return pulse drops the service level back to idle. With the unmaskable option on, source 0 can never be masked off.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, req_o is 0, level_o is 7, vec_addr_o is 0x0000 and mask_o equals the reset mask (default 0xFF) with bit 0 forced to 1 when the unmaskable option is on.
- R2: A one-cycle request on an enabled source is remembered. Counting the rising edge that samples the request as the first edge, req_o goes high after the third edge.
- R3: When source n is taken, vec_addr_o equals the table base (default 0x0080) plus 2·n, and level_o equals n.
- R4: When several sources are eligible in the same cycle, only the lowest-index one is taken. The others stay pending and are taken later, once they become eligible.
- R5: Source 0 is always eligible when pending. Source n (1..6) is eligible only when level_o > n. Source 7 is eligible only when level_o is 7.
- R6: A return pulse (rti_i) sets level_o to 7 on the next edge, unless a source is taken on that same edge.
- R7: While a request is outstanding, no new source is taken. vec_addr_o and level_o change only through vec_inc_i.
- R8: req_o stays high through the second edge after the edge that samples accept_i, and is low after the third edge.
- R9: A mask write loads mask_wdata_i into the mask, with bit 0 forced to 1 when the unmaskable option is on. mask_o shows the mask from the next edge on.
- R10: A request (hardware or software) on a source whose mask bit is 0 is ignored. It is not remembered when the mask is later opened.
- R11: A software request pulse on soft_irq_i has the same effect as a hardware request on the same source.
- R12: A pulse on vec_inc_i adds 1 to vec_addr_o on the next edge.
- R13: Reset clears all pending requests and any outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Hardware request lines, one per source |
| soft_irq_i | input | 8 | Software request pulses, one per source |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | New mask value (accumulator contents) |
| mask_o | output | 8 | Current enable mask |
| vec_inc_i | input | 1 | Step the vector address by one |
| rti_i | input | 1 | Return from interrupt: service level back to idle |
| accept_i | input | 1 | Core has accepted the request |
| req_o | output | 1 | Interrupt request strobe to the core |
| vec_addr_o | output | 16 | Vector address of the selected source |
| level_o | output | 3 | Service level (index of the source in service, 7 when idle) |

## Verification
A corrupted pending bit shows up as a request that never arrives, or one that arrives with no stimulus. The bench sees either within a few cycles, because a lone eligible source is presented three edges after its request. A wrong service level shows up as a missing or unwanted preemption, so every ordered pair of sources is raised together. Each pair is checked for which source appears first, and that the second waits for the return pulse. A stuck busy or acknowledge stage shows up as a request that never drops, or that drops at the wrong edge after accept; this is checked to the exact cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int SRC_N  = 8;
    localparam int LVL_W  = $clog2(SRC_N);
    localparam int ADDR_W = 16;

    typedef logic [SRC_N-1:0]  src_vec_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam lvl_t LVL_IDLE = lvl_t'(SRC_N - 1);

    typedef struct packed {
        src_vec_t pend;
        src_vec_t mask;
        addr_t    vec;
        lvl_t     level;
        logic     busy;
        logic     req;
    } pic_state_t;

    function automatic src_vec_t force_nmi(src_vec_t m, bit nmi_on);
        src_vec_t r;
        r = m;
        if (nmi_on) begin
            r[0] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_pend_next.sv
module pic_pend_next
    import pic_pkg::*;
(
    input  src_vec_t pend_q_i,
    input  src_vec_t hw_i,
    input  src_vec_t sw_i,
    input  src_vec_t mask_i,
    input  logic     clr_en_i,
    input  lvl_t     clr_idx_i,
    output src_vec_t pend_d_o
);

    always_comb begin
        pend_d_o = pend_q_i | ((hw_i | sw_i) & mask_i);
        if (clr_en_i) begin
            pend_d_o[clr_idx_i] = 1'b0;
        end
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  src_vec_t pend_i,
    input  lvl_t     level_i,
    output logic     win_valid_o,
    output lvl_t     win_idx_o
);

    src_vec_t elig;

    for (genvar n = 0; n < SRC_N; n++) begin : g_elig
        if (n == 0) begin : g_top
            assign elig[n] = pend_i[n];
        end else if (n == SRC_N - 1) begin : g_low
            assign elig[n] = pend_i[n] & (level_i == LVL_IDLE);
        end else begin : g_mid
            assign elig[n] = pend_i[n] & (level_i > lvl_t'(n));
        end
    end

    always_comb begin
        win_valid_o = |elig;
        win_idx_o   = '0;
        for (int k = SRC_N - 1; k >= 0; k--) begin
            if (elig[k]) begin
                win_idx_o = lvl_t'(k);
            end
        end
    end

endmodule

// File: rtl/pic_ack_delay.sv
module pic_ack_delay #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic ack_o
);

    logic [DEPTH-1:0] stage_q;

    if (DEPTH == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= accept_i;
            end
        end
    end else begin : g_many
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= {stage_q[DEPTH-2:0], accept_i};
            end
        end
    end

    assign ack_o = stage_q[DEPTH-1];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter logic [15:0] VEC_BASE  = 16'h0080,
    parameter logic [7:0]  RST_MASK  = 8'hFF,
    parameter bit          NMI_EN    = 1'b1,
    parameter int          ACK_DEPTH = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  irq_i,
    input  logic [7:0]  soft_irq_i,
    input  logic        mask_wr_i,
    input  logic [7:0]  mask_wdata_i,
    output logic [7:0]  mask_o,
    input  logic        vec_inc_i,
    input  logic        rti_i,
    input  logic        accept_i,
    output logic        req_o,
    output logic [15:0] vec_addr_o,
    output logic [2:0]  level_o
);

    localparam src_vec_t MASK_AT_RESET = force_nmi(src_vec_t'(RST_MASK), NMI_EN);

    pic_state_t st_q, st_d;
    src_vec_t   pend_next;
    logic       win_valid;
    lvl_t       win_idx;
    logic       ack;
    logic       take;

    assign take = ~st_q.busy & win_valid;

    pic_arbiter u_arb (
        .pend_i      (st_q.pend),
        .level_i     (st_q.level),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    pic_pend_next u_pend (
        .pend_q_i  (st_q.pend),
        .hw_i      (irq_i),
        .sw_i      (soft_irq_i),
        .mask_i    (st_q.mask),
        .clr_en_i  (take),
        .clr_idx_i (win_idx),
        .pend_d_o  (pend_next)
    );

    pic_ack_delay #(.DEPTH(ACK_DEPTH)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept_i),
        .ack_o    (ack)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_next;
        if (take) begin
            st_d.vec   = VEC_BASE + (addr_t'(win_idx) << 1);
            st_d.level = win_idx;
            st_d.busy  = 1'b1;
        end else if (rti_i) begin
            st_d.level = LVL_IDLE;
        end
        if (ack) begin
            st_d.busy = 1'b0;
        end
        st_d.req = st_q.busy & ~ack;
        if (mask_wr_i) begin
            st_d.mask = force_nmi(mask_wdata_i, NMI_EN);
        end
        if (vec_inc_i) begin
            st_d.vec = st_q.vec + addr_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.mask  <= MASK_AT_RESET;
            st_q.vec   <= '0;
            st_q.level <= LVL_IDLE;
            st_q.busy  <= 1'b0;
            st_q.req   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o     = st_q.mask;
    assign req_o      = st_q.req;
    assign vec_addr_o = st_q.vec;
    assign level_o    = st_q.level;

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter logic [15:0] VEC_BASE = 16'h0080,
    parameter bit          NMI_EN   = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_i,
    input logic        req_o,
    input logic [15:0] vec_addr_o,
    input logic [2:0]  level_o,
    input logic [7:0]  mask_o,
    input logic        mask_wr_i,
    input logic [7:0]  mask_wdata_i,
    input logic        vec_inc_i,
    input logic        rti_i
);

    AST_VEC_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> vec_addr_o == VEC_BASE + {12'd0, level_o, 1'b0}); // R3

    AST_NESTED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> (level_o == 3'd0) || ($past(level_o) > level_o)
                          || ($past(level_o) == 3'd7 && level_o == 3'd7)); // R5

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> busy_i); // R8

    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o) && !$past(vec_inc_i)) |-> $stable(vec_addr_o)); // R7

    AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rti_i) && !$rose(busy_i)) |-> level_o == 3'd7); // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_wr_i) |-> mask_o == ($past(mask_wdata_i) | {7'd0, NMI_EN})); // R9

    AST_NMI_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        NMI_EN |-> mask_o[0]); // R9

endmodule

bind prio_irq_ctrl pic_checker #(
    .VEC_BASE (VEC_BASE),
    .NMI_EN   (NMI_EN)
) u_pic_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (st_q.busy),
    .req_o        (req_o),
    .vec_addr_o   (vec_addr_o),
    .level_o      (level_o),
    .mask_o       (mask_o),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .vec_inc_i    (vec_inc_i),
    .rti_i        (rti_i)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    localparam logic [15:0] BASE = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  irq_i, soft_irq_i, mask_wdata_i, mask_o;
    logic        mask_wr_i, vec_inc_i, rti_i, accept_i, req_o;
    logic [15:0] vec_addr_o;
    logic [2:0]  level_o;

    int n_chk = 0;
    int n_err = 0;
    bit got;

    always #10 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .soft_irq_i(soft_irq_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .mask_o(mask_o),
        .vec_inc_i(vec_inc_i), .rti_i(rti_i), .accept_i(accept_i),
        .req_o(req_o), .vec_addr_o(vec_addr_o), .level_o(level_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw(input logic [7:0] b);
        irq_i = b; tick(1); irq_i = '0;
    endtask

    task automatic sw(input logic [7:0] b);
        soft_irq_i = b; tick(1); soft_irq_i = '0;
    endtask

    task automatic wait_req(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (req_o) begin
                ok = 1'b1;
                break;
            end
            tick(1);
        end
    endtask

    task automatic do_accept();
        accept_i = 1'b1; tick(1); accept_i = 1'b0; tick(4);
    endtask

    task automatic do_rti();
        rti_i = 1'b1; tick(1); rti_i = 1'b0; tick(1);
    endtask

    task automatic mask_write(input logic [7:0] b);
        mask_wr_i = 1'b1; mask_wdata_i = b; tick(1); mask_wr_i = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_i = '0; soft_irq_i = '0; mask_wr_i = 1'b0;
        mask_wdata_i = '0; vec_inc_i = 1'b0; rti_i = 1'b0; accept_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 req", int'(req_o), 0);
        chk("R1 level", int'(level_o), 7);
        chk("R1 vec", int'(vec_addr_o), 0);
        chk("R1 mask", int'(mask_o), 'hFF);

        // R2 request latency, R3 vector, R8 accept latency
        hw(8'h08);
        tick(1);
        chk("R2 req low after edge 2", int'(req_o), 0);
        tick(1);
        chk("R2 req high after edge 3", int'(req_o), 1);
        chk("R3 level", int'(level_o), 3);
        chk("R3 vec", int'(vec_addr_o), int'(BASE) + 6);
        accept_i = 1'b1; tick(1); accept_i = 1'b0;
        tick(2);
        chk("R8 req held after edge E+2", int'(req_o), 1);
        tick(1);
        chk("R8 req low after edge E+3", int'(req_o), 0);
        tick(1);
        do_rti();
        chk("R6 level idle", int'(level_o), 7);

        // R3 / R12 single sources via hardware, R11 via software
        for (int n = 0; n < 8; n++) begin
            hw(8'(1 << n));
            wait_req(got);
            chk("R3 hw taken", int'(got), 1);
            chk("R3 hw level", int'(level_o), n);
            chk("R3 hw vec", int'(vec_addr_o), int'(BASE) + 2 * n);
            vec_inc_i = 1'b1; tick(1); vec_inc_i = 1'b0;
            chk("R12 vec step", int'(vec_addr_o), int'(BASE) + 2 * n + 1);
            do_accept();
            do_rti();
            sw(8'(1 << n));
            wait_req(got);
            chk("R11 soft taken", int'(got), 1);
            chk("R11 soft level", int'(level_o), n);
            do_accept();
            do_rti();
        end

        // R4 / R5 / R6 every pair raised together
        for (int i = 0; i < 7; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                hw(8'((1 << i) | (1 << j)));
                wait_req(got);
                chk("R4 first is higher", int'(level_o), i);
                do_accept();
                tick(4);
                chk("R5 lower waits", int'(req_o), 0);
                do_rti();
                wait_req(got);
                chk("R4 remembered taken", int'(got), 1);
                chk("R6 lower level", int'(level_o), j);
                do_accept();
                do_rti();
            end
        end

        // R5 preemption against level in service
        hw(8'h08);
        wait_req(got);
        do_accept();
        hw(8'h20);
        tick(8);
        chk("R5 below level blocked", int'(req_o), 0);
        hw(8'h02);
        wait_req(got);
        chk("R5 above level preempts", int'(level_o), 1);
        do_accept();
        do_rti();
        wait_req(got);
        chk("R4 pending after return", int'(level_o), 5);
        do_accept();
        do_rti();

        // R7 no arbitration while busy
        hw(8'h20);
        wait_req(got);
        hw(8'h01);
        tick(6);
        chk("R7 level held", int'(level_o), 5);
        chk("R7 vec held", int'(vec_addr_o), int'(BASE) + 10);
        do_accept();
        wait_req(got);
        chk("R7 waiting source after accept", int'(level_o), 0);
        do_accept();
        do_rti();

        // R9 / R10 mask
        mask_write(8'h00);
        chk("R9 mask nmi forced", int'(mask_o), 'h01);
        hw(8'h08);
        sw(8'h10);
        tick(8);
        chk("R10 masked ignored", int'(req_o), 0);
        mask_write(8'hFF);
        chk("R9 mask open", int'(mask_o), 'hFF);
        tick(8);
        chk("R10 not remembered", int'(req_o), 0);
        mask_write(8'h5A);
        chk("R9 mask pattern", int'(mask_o), 'h5B);
        mask_write(8'h00);
        hw(8'h01);
        wait_req(got);
        chk("R9 source 0 unmaskable", int'(got), 1);
        chk("R9 source 0 level", int'(level_o), 0);
        do_accept();
        do_rti();
        mask_write(8'hFF);

        // R13 reset clears pending and busy
        hw(8'h04);
        wait_req(got);
        hw(8'h40);
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        chk("R13 req cleared", int'(req_o), 0);
        tick(10);
        chk("R13 no stale pending", int'(req_o), 0);
        chk("R13 level idle", int'(level_o), 7);

        summary();
        $finish;
    end

endmodule